// File: doc/BRIEF.md
# Read-Only Cartridge Port to 8-bit ISA I/O Bridge

This block lets a host whose cartridge slot can only issue read cycles drive an 8-bit ISA-style register bank, such as a network controller. The host owns two 64 KiB ROM windows, each with its own active-low select. A read that falls in the first window becomes an ISA I/O read. The peripheral byte is latched and returned on the host data lines. A read that falls in the second window becomes an ISA I/O write. The byte to write travels on host address bits, because the slot has no way to carry write data on its data lines.

The peripheral port number comes from a five-bit address field, so consecutive ports lie 512 bytes apart in host space. Every ISA cycle follows the same sequence: one clock of address and data setup, a strobe of fixed length that can be stretched by the peripheral's ready line up to a bounded timeout, and one clock of hold. The host is expected to find events by polling status registers. No interrupt path exists. All host inputs are taken to be synchronous to `clk`.

Top module: `cartport_isa_bridge`

## Requirements
- R1: While `win_rd_sel_n` is low and host A23..A16 equal 0xFA with A15..A14 both zero, the bridge runs one ISA I/O read. Any other upper address value starts no ISA cycle.
- R2: While `win_wr_sel_n` is low and host A23..A16 equal 0xFB with A15..A14 both zero, the bridge runs one ISA I/O write. If both selects are low, the read takes priority.
- R3: Host A13..A9 appear on `isa_addr[4:0]` in the same order, with A13 on bit 4.
- R4: On a write, `isa_dout[7:0]` carries host A8..A1, with A8 as bit 7.
- R5: `host_dq_oe` is high only while `win_rd_sel_n` is low and after the read byte has been latched. `host_dq` then equals the byte the peripheral presented when the strobe ended. During a write-window access the bridge never drives the host data lines.
- R6: Each select assertion gives exactly one ISA cycle. A new cycle needs both selects to have been seen high first.
- R7: When the peripheral is ready, `isa_ior_n` or `isa_iow_n` is low for exactly STB_CLKS clocks (3 by default). The two strobes are never low together.
- R8: The address, and on writes the data, are valid one clock before the strobe falls and stay stable for one clock after it rises.
- R9: While `isa_rdy` is low, the strobe is held after its minimum length. Once `isa_rdy` is high again, the strobe ends, so its length is max(STB_CLKS, clocks until ready) plus the ending clock. The strobe never lasts longer than STB_CLKS+WAIT_MAX clocks (19 by default). After that the bridge returns to idle and accepts new cycles.
- R10: A synchronous active-low reset leaves both strobes high and `host_dq_oe` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bridge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| host_addr | input | 23 | Host address A23..A1 |
| win_rd_sel_n | input | 1 | Read-window select, active low |
| win_wr_sel_n | input | 1 | Write-window select, active low |
| host_dq | output | 8 | Byte returned to the host |
| host_dq_oe | output | 1 | Drive enable for `host_dq` |
| isa_addr | output | 5 | Peripheral port number |
| isa_dout | output | 8 | Peripheral write data |
| isa_din | input | 8 | Peripheral read data |
| isa_ior_n | output | 1 | I/O read strobe, active low |
| isa_iow_n | output | 1 | I/O write strobe, active low |
| isa_rdy | input | 1 | Peripheral channel ready |

## Verification
Reads and writes are issued to several ports with distinct data patterns, including 0x00, 0xFF and alternating bits. This separates swapped or shifted address fields from a correct mapping and shows whether the write byte is taken from the right address bits. Accesses with a wrong upper address byte, or with A15 set, must produce no strobe. One select held for a long time must produce exactly one strobe, which rules out retriggering. The ready line is held low for a moderate stall and then for a very long one. This tells the stretch path apart from the timeout path, and a follow-up access confirms that the bridge went back to idle.

// File: rtl/cpb_pkg.sv
// Shared types for the cartridge-port ISA bridge.
// Assumes: 5-bit peripheral port field and 8-bit data path.
package cpb_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SETUP,
        ST_STROBE,
        ST_HOLD
    } seq_state_t;

    typedef struct packed {
        logic       is_wr;
        logic [4:0] port;
        logic [7:0] wdata;
    } isa_req_t;
endpackage

// File: rtl/cpb_decode.sv
// Window decoder: turns host select and address into an ISA request.
// Assumes: host_addr holds A23..A1; the read window wins if both selects are low.
module cpb_decode
    import cpb_pkg::*;
#(
    parameter logic [7:0] RD_BASE = 8'hFA,
    parameter logic [7:0] WR_BASE = 8'hFB
) (
    input  logic [23:1] host_addr,
    input  logic        win_rd_sel_n,
    input  logic        win_wr_sel_n,
    output logic        req_valid,
    output isa_req_t    req,
    output logic        bus_idle
);
    logic low_ok;
    logic rd_hit;
    logic wr_hit;

    // Window match on the high address byte plus a clear A15..A14.
    always_comb begin
        low_ok    = (host_addr[15:14] == 2'b00);
        rd_hit    = !win_rd_sel_n && (host_addr[23:16] == RD_BASE) && low_ok;
        wr_hit    = !win_wr_sel_n && (host_addr[23:16] == WR_BASE) && low_ok;
        req_valid = rd_hit || wr_hit;
        bus_idle  = win_rd_sel_n && win_wr_sel_n;
    end

    // Request fields: port from A13..A9, write byte from A8..A1.
    always_comb begin
        req.is_wr = !rd_hit;
        req.port  = host_addr[13:9];
        req.wdata = host_addr[8:1];
    end
endmodule

// File: rtl/cpb_seq.sv
// ISA cycle sequencer: setup, strobe (stretchable and bounded), hold.
// Assumes: one request per select assertion; re-armed once both selects are high.
module cpb_seq
    import cpb_pkg::*;
#(
    parameter int STB_CLKS = 3,
    parameter int WAIT_MAX = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  isa_req_t   req,
    input  logic       bus_idle,
    input  logic       isa_rdy,
    output logic [4:0] isa_addr,
    output logic [7:0] isa_dout,
    output logic       isa_ior_n,
    output logic       isa_iow_n,
    output logic       latch_en
);
    localparam int LIMIT = STB_CLKS + WAIT_MAX - 1;
    localparam int CNT_W = $clog2(LIMIT + 1);

    seq_state_t       state;
    isa_req_t         cur;
    logic [CNT_W-1:0] cnt;
    logic             armed;
    logic             done;

    // Strobe end: minimum length met and ready, or the timeout reached.
    always_comb begin
        done = ((cnt >= CNT_W'(STB_CLKS - 1)) && isa_rdy) || (cnt == CNT_W'(LIMIT));
    end

    // Cycle state machine with a one-shot arm per select assertion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cur   <= '0;
            cnt   <= '0;
            armed <= 1'b1;
        end else begin
            if (bus_idle) armed <= 1'b1;
            case (state)
                ST_IDLE: begin
                    if (armed && req_valid) begin
                        cur   <= req;
                        armed <= 1'b0;
                        state <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    cnt   <= '0;
                    state <= ST_STROBE;
                end
                ST_STROBE: begin
                    cnt <= cnt + 1'b1;
                    if (done) state <= ST_HOLD;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus outputs come straight from the held request and state.
    always_comb begin
        isa_addr  = cur.port;
        isa_dout  = cur.wdata;
        isa_ior_n = !((state == ST_STROBE) && !cur.is_wr);
        isa_iow_n = !((state == ST_STROBE) && cur.is_wr);
        latch_en  = (state == ST_STROBE) && done && !cur.is_wr;
    end
endmodule

// File: rtl/cpb_rdret.sv
// Read return path: captures the peripheral byte and drives it to the host.
// Assumes: the read select stays low until the host has taken the byte.
module cpb_rdret (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       latch_en,
    input  logic [7:0] isa_din,
    input  logic       win_rd_sel_n,
    output logic [7:0] host_dq,
    output logic       host_dq_oe
);
    logic [7:0] rd_byte;
    logic       rd_ok;

    // Capture on strobe end; forget the byte once the read select goes high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_byte <= '0;
            rd_ok   <= 1'b0;
        end else if (latch_en) begin
            rd_byte <= isa_din;
            rd_ok   <= 1'b1;
        end else if (win_rd_sel_n) begin
            rd_ok   <= 1'b0;
        end
    end

    // Drive the host lines only inside a live read-window access.
    always_comb begin
        host_dq    = rd_byte;
        host_dq_oe = rd_ok && !win_rd_sel_n;
    end
endmodule

// File: rtl/cartport_isa_bridge.sv
// Top level: read-only cartridge slot to 8-bit ISA I/O bridge.
// Assumes: host signals synchronous to clk; the peripheral answers reads combinationally.
module cartport_isa_bridge
    import cpb_pkg::*;
#(
    parameter int         STB_CLKS = 3,
    parameter int         WAIT_MAX = 16,
    parameter logic [7:0] RD_BASE  = 8'hFA,
    parameter logic [7:0] WR_BASE  = 8'hFB
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [23:1] host_addr,
    input  logic        win_rd_sel_n,
    input  logic        win_wr_sel_n,
    output logic [7:0]  host_dq,
    output logic        host_dq_oe,
    output logic [4:0]  isa_addr,
    output logic [7:0]  isa_dout,
    input  logic [7:0]  isa_din,
    output logic        isa_ior_n,
    output logic        isa_iow_n,
    input  logic        isa_rdy
);
    logic     req_valid;
    isa_req_t req;
    logic     bus_idle;
    logic     latch_en;

    cpb_decode #(.RD_BASE(RD_BASE), .WR_BASE(WR_BASE)) u_dec (
        .host_addr    (host_addr),
        .win_rd_sel_n (win_rd_sel_n),
        .win_wr_sel_n (win_wr_sel_n),
        .req_valid    (req_valid),
        .req          (req),
        .bus_idle     (bus_idle)
    );

    cpb_seq #(.STB_CLKS(STB_CLKS), .WAIT_MAX(WAIT_MAX)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req       (req),
        .bus_idle  (bus_idle),
        .isa_rdy   (isa_rdy),
        .isa_addr  (isa_addr),
        .isa_dout  (isa_dout),
        .isa_ior_n (isa_ior_n),
        .isa_iow_n (isa_iow_n),
        .latch_en  (latch_en)
    );

    cpb_rdret u_ret (
        .clk          (clk),
        .rst_n        (rst_n),
        .latch_en     (latch_en),
        .isa_din      (isa_din),
        .win_rd_sel_n (win_rd_sel_n),
        .host_dq      (host_dq),
        .host_dq_oe   (host_dq_oe)
    );
endmodule

// File: rtl/cartport_isa_bridge_chk.sv
// Protocol checker for the bridge ports, bound into every instance.
// Assumes: the same parameters as the bridge it watches.
module cartport_isa_bridge_chk #(
    parameter int STB_CLKS = 3,
    parameter int WAIT_MAX = 16
) (
    input logic        clk,
    input logic        rst_n,
    input logic        win_rd_sel_n,
    input logic        win_wr_sel_n,
    input logic        host_dq_oe,
    input logic [4:0]  isa_addr,
    input logic [7:0]  isa_dout,
    input logic        isa_ior_n,
    input logic        isa_iow_n
);
    logic        strb_n;
    logic [15:0] lowrun;
    logic        seen;

    assign strb_n = isa_ior_n && isa_iow_n;

    // Run length of the current low strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       lowrun <= '0;
        else if (!strb_n) lowrun <= lowrun + 1'b1;
        else              lowrun <= '0;
    end

    // Marks that a strobe already ran within the present select assertion.
    always_ff @(posedge clk) begin
        if (!rst_n)                             seen <= 1'b0;
        else if (win_rd_sel_n && win_wr_sel_n)  seen <= 1'b0;
        else if (!strb_n)                       seen <= 1'b1;
    end

    p_excl_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(!isa_ior_n && !isa_iow_n));

    p_setup_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n) |-> ($stable(isa_addr) && $stable(isa_dout)));

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(strb_n) |=> ($stable(isa_addr) && $stable(isa_dout)));

    p_oe_rdwin_r5: assert property (@(posedge clk) disable iff (!rst_n)
        host_dq_oe |-> !win_rd_sel_n);

    p_timeout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !strb_n |-> (lowrun < 16'(STB_CLKS + WAIT_MAX)));

    p_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(strb_n) |-> !seen);

    p_reset_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (isa_ior_n && isa_iow_n && !host_dq_oe));
endmodule

bind cartport_isa_bridge cartport_isa_bridge_chk #(
    .STB_CLKS(STB_CLKS),
    .WAIT_MAX(WAIT_MAX)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_rd_sel_n (win_rd_sel_n),
    .win_wr_sel_n (win_wr_sel_n),
    .host_dq_oe   (host_dq_oe),
    .isa_addr     (isa_addr),
    .isa_dout     (isa_dout),
    .isa_ior_n    (isa_ior_n),
    .isa_iow_n    (isa_iow_n)
);

// File: tb/cartport_isa_bridge_tb_top.sv
// Scoreboard bench: the host driver queues expected ISA cycles, a bus monitor checks them.
module cartport_isa_bridge_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 20000;

    typedef struct {
        bit       wr;
        bit [4:0] port;
        bit [7:0] data;
        int       width;
    } txn_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:1] host_addr = '0;
    logic        win_rd_sel_n = 1'b1;
    logic        win_wr_sel_n = 1'b1;
    logic [7:0]  host_dq;
    logic        host_dq_oe;
    logic [4:0]  isa_addr;
    logic [7:0]  isa_dout;
    logic [7:0]  isa_din;
    logic        isa_ior_n;
    logic        isa_iow_n;
    logic        isa_rdy;

    int   total = 0;
    int   bad = 0;
    txn_t exp_q[$];
    logic [7:0] pmem [32];
    logic [7:0] emem [32];
    int   lowcnt = 0;
    int   stall_len = 0;
    int   strobes = 0;
    bit   mon_low = 0;
    int   mon_w = 0;
    bit   mon_wr = 0;
    logic [4:0] mon_a = '0;
    logic [7:0] mon_d = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cartport_isa_bridge dut_i (
        .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
        .win_rd_sel_n(win_rd_sel_n), .win_wr_sel_n(win_wr_sel_n),
        .host_dq(host_dq), .host_dq_oe(host_dq_oe),
        .isa_addr(isa_addr), .isa_dout(isa_dout), .isa_din(isa_din),
        .isa_ior_n(isa_ior_n), .isa_iow_n(isa_iow_n), .isa_rdy(isa_rdy)
    );

    // Peripheral model: register file with a programmable ready stall.
    assign isa_din = pmem[isa_addr];
    assign isa_rdy = (lowcnt >= stall_len);
    always @(posedge clk) begin
        lowcnt <= (!isa_ior_n || !isa_iow_n) ? lowcnt + 1 : 0;
        if (!isa_iow_n) pmem[isa_addr] <= isa_dout;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [23:1] mk(input logic [7:0] hi, input logic [4:0] port,
                                       input logic [7:0] d);
        logic [23:1] a;
        a = '0;
        a[23:16] = hi;
        a[13:9]  = port;
        a[8:1]   = d;
        return a;
    endfunction

    // Bus monitor: measures each strobe and compares it with the queue head.
    always @(negedge clk) begin
        if (!isa_ior_n || !isa_iow_n) begin
            if (!mon_low) strobes++;
            mon_low = 1;
            mon_w++;
            mon_wr = !isa_iow_n;
            mon_a = isa_addr;
            mon_d = isa_dout;
        end else if (mon_low) begin
            mon_low = 0;
            if (exp_q.size() == 0) begin
                check(0, "R6 unexpected strobe", 1, 0);
            end else begin
                txn_t e;
                e = exp_q.pop_front();
                check(mon_wr == e.wr, "R1/R2 cycle kind", int'(mon_wr), int'(e.wr));
                check(mon_a == e.port, "R3 port field", int'(mon_a), int'(e.port));
                if (e.wr) check(mon_d == e.data, "R4 write byte", int'(mon_d), int'(e.data));
                check(mon_w == e.width, "R7/R9 strobe width", mon_w, e.width);
            end
            mon_w = 0;
        end
    end

    // Host access: one select assertion, held for hold_c clocks.
    task automatic host_access(input bit wr, input logic [4:0] port, input logic [7:0] d,
                               input int width, input int hold_c);
        txn_t t;
        t.wr = wr; t.port = port; t.data = d; t.width = width;
        exp_q.push_back(t);
        @(negedge clk);
        host_addr = mk(wr ? 8'hFB : 8'hFA, port, wr ? d : 8'h00);
        if (wr) win_wr_sel_n = 1'b0; else win_rd_sel_n = 1'b0;
        repeat (hold_c) @(negedge clk);
        if (wr) begin
            check(host_dq_oe == 1'b0, "R5 no drive in write window", int'(host_dq_oe), 0);
            emem[port] = d;
        end else begin
            check(host_dq_oe == 1'b1, "R5 read drive enable", int'(host_dq_oe), 1);
            check(host_dq == emem[port], "R1 R5 read byte", int'(host_dq), int'(emem[port]));
        end
        win_rd_sel_n = 1'b1;
        win_wr_sel_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        check(0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < 32; i++) begin
            pmem[i] = 8'(8'h30 + i * 7);
            emem[i] = 8'(8'h30 + i * 7);
        end
        repeat (4) @(negedge clk);
        // R10: idle outputs under reset and right after it.
        check(isa_ior_n && isa_iow_n, "R10 strobes idle in reset", int'({isa_ior_n, isa_iow_n}), 3);
        check(!host_dq_oe, "R10 data lines released", int'(host_dq_oe), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(isa_ior_n && isa_iow_n, "R10 strobes idle after reset", int'({isa_ior_n, isa_iow_n}), 3);

        // R1 R3 R7: reads from distinct ports with a ready peripheral.
        host_access(0, 5'd0, 8'h00, 3, 12);
        host_access(0, 5'd31, 8'h00, 3, 12);
        host_access(0, 5'd10, 8'h00, 3, 12);
        // R2 R4 R8: writes with edge and alternating byte patterns.
        host_access(1, 5'd21, 8'hA5, 3, 12);
        host_access(1, 5'd1, 8'hFF, 3, 12);
        host_access(1, 5'd16, 8'h00, 3, 12);
        host_access(1, 5'd2, 8'h5A, 3, 12);
        // Read back what was written through the peripheral.
        host_access(0, 5'd21, 8'h00, 3, 12);
        host_access(0, 5'd2, 8'h00, 3, 12);

        // R1: wrong upper byte and A15 set give no ISA cycle.
        s0 = strobes;
        @(negedge clk);
        host_addr = mk(8'hF0, 5'd3, 8'h00);
        win_rd_sel_n = 1'b0;
        repeat (10) @(negedge clk);
        host_addr = mk(8'hFA, 5'd3, 8'h00);
        host_addr[15] = 1'b1;
        repeat (10) @(negedge clk);
        check(strobes == s0, "R1 outside window ignored", strobes - s0, 0);
        check(!host_dq_oe, "R5 no drive outside window", int'(host_dq_oe), 0);
        win_rd_sel_n = 1'b1;
        repeat (3) @(negedge clk);

        // R6: one long write select gives a single cycle.
        s0 = strobes;
        host_access(1, 5'd7, 8'h3C, 3, 60);
        check(strobes - s0 == 1, "R6 single cycle per select", strobes - s0, 1);

        // R9: stall of 7 clocks stretches the strobe to 8.
        stall_len = 7;
        host_access(0, 5'd7, 8'h00, 8, 20);
        host_access(1, 5'd9, 8'hC3, 8, 20);
        // R9: endless stall ends at the timeout, then normal service resumes.
        stall_len = 1000;
        host_access(1, 5'd12, 8'h81, 19, 30);
        host_access(0, 5'd12, 8'h00, 19, 30);
        stall_len = 0;
        host_access(0, 5'd9, 8'h00, 3, 12);

        repeat (5) @(negedge clk);
        check(exp_q.size() == 0, "R6 all cycles observed", exp_q.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule